// File: doc/BRIEF.md
# Configurable Reset Source Controller

This block sits between four reset requesters (an external reset pin, a brownout detector and two watchdog timers) and the chip's reset distribution. Each requester has its own 2-bit policy field in a small control register. The field steers an incoming request either to a plain system reset or to a simulated power-on sequence. The block drives two single-cycle pulse outputs, one for each kind of reset, and records in a cause register which sources fired.

Requests arrive asynchronously. Each one passes through a synchronizer, and only its rising edge counts as an event. A three-state machine turns the events of one cycle into at most one output pulse. The states are `ST_IDLE`, `ST_SYS` and `ST_SIM`. From any state, the machine goes to `ST_SIM` when any event in that cycle is steered to a simulated POR. It goes to `ST_SYS` when the only events are steered to a system reset. It goes to `ST_IDLE` when there is no event. Software reaches the policy register at word address 0 and the cause register at word address 1 over a simple single-cycle bus.

The true power-on input `por_n` is asynchronous and active low. It is the only thing that resets the policy register. The block's own output pulses do not reset it.

Top module: `rst_src_ctrl`

## Requirements
- R1: After a true power-on reset, the policy register (address 0) reads 0x00FFFFFF. Every policy field is then 0x3, bits 23:8 read as ones and bits 31:24 read as zero.
- R2: The policy fields sit at these bit positions: external pin at 1:0, brownout at 3:2, watchdog 0 at 5:4 and watchdog 1 at 7:6. A field value of 0x2 makes its source produce a `sys_rst_pulse` and no `sim_por_pulse`.
- R3: A field value of 0x3, 0x0 or 0x1 makes its source produce a `sim_por_pulse` and no `sys_rst_pulse`.
- R4: Every accepted event sets the cause bit of its source in the cause register (address 1). The bit positions are: bit 1 for the external pin, bit 2 for brownout, bit 3 for watchdog 0 and bit 4 for watchdog 1. This holds for both kinds of reset.
- R5: A true power-on reset leaves the cause register at 0x01, with the POR bit (bit 0) set and every other bit clear.
- R6: A policy write takes effect from the next event on. The policy value survives every system reset and simulated POR that the block issues.
- R7: While `bor_irq_mode` is 1, a brownout request produces no pulse of either kind and sets no cause bit.
- R8: When several sources have events in the same cycle, a single `sim_por_pulse` is issued if any of them is steered to a simulated POR. All of their cause bits are set.
- R9: Writing a 1 to a cause bit clears it. Writing a 0 leaves it unchanged. A set in the same cycle takes priority over a clear.
- R10: Writes to bits 31:8 of the policy register are ignored.
- R11: Each accepted event gives a pulse exactly one cycle wide. A request held high gives only one event. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | True power-on reset, asynchronous, active low |
| req_ext | input | 1 | External reset pin request (asynchronous) |
| req_bor | input | 1 | Brownout request (asynchronous) |
| req_wd0 | input | 1 | Watchdog 0 request (asynchronous) |
| req_wd1 | input | 1 | Watchdog 1 request (asynchronous) |
| bor_irq_mode | input | 1 | 1: brownout is handled as an interrupt, so no reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 2 | Word address: 0 policy, 1 cause |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| sys_rst_pulse | output | 1 | One-cycle system reset |
| sim_por_pulse | output | 1 | One-cycle simulated POR |

## Verification
The bench sets the policy values 0x0 and 0x1 and expects a simulated POR for both. A decoder that treated either value as a system reset would issue the wrong pulse. It fires all four sources in one cycle with mixed policies, which catches a priority that lets the system reset win, or that sets only one cause bit. It holds a request high for several cycles, which exposes a missing edge detector through extra pulses. It raises brownout while interrupt mode is selected and expects no pulse and no new cause bit. It checks that the policy value is kept across the block's own resets, and that a new power-on brings the policy register back to 0x00FFFFFF and the cause register to 0x01.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int N_SRC   = 4;
    localparam int FIELD_W = 2;
    localparam int POL_W   = N_SRC * FIELD_W;
    localparam int CAUSE_W = N_SRC + 1;
    localparam int DATA_W  = 32;
    localparam logic [FIELD_W-1:0] POL_SYS = 2'h2;
    localparam logic [POL_W-1:0]   POL_RST = '1;
    localparam logic [DATA_W-1:0]  POL_RSVD_RD = 32'h00FF_FF00;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYS  = 2'd1,
        ST_SIM  = 2'd2
    } rsc_state_t;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] req_async,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], req_async[i]};
                last  <= chain[STAGES-1];
            end
        end
        assign rise[i] = chain[STAGES-1] & ~last;

        // R11
        edge_single_chk: assert property (@(posedge clk) disable iff (!por_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/rsc_policy.sv
module rsc_policy
    import rsc_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [POL_W-1:0] wdata,
    output logic [POL_W-1:0] pol_q,
    output logic [N_SRC-1:0] sim_mask
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pol_q <= POL_RST;
        else if (wr_en) pol_q <= wdata;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_dec
        assign sim_mask[i] = (pol_q[i*FIELD_W +: FIELD_W] != POL_SYS);
    end

    // R6
    policy_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> $stable(pol_q));
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
    import rsc_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic [N_SRC-1:0]   set_src,
    input  logic               clr_en,
    input  logic [CAUSE_W-1:0] clr_bits,
    output logic [CAUSE_W-1:0] cause_q
);
    logic [CAUSE_W-1:0] set_v, clr_v;
    assign set_v = {set_src, 1'b0};
    assign clr_v = clr_en ? clr_bits : '0;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= CAUSE_W'(1);
        else        cause_q <= (cause_q & ~clr_v) | set_v;
    end

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((cause_q & $past(clr_v & ~set_v)) == '0));
    // R4
    set_chk: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((cause_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rsc_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        req_ext,
    input  logic        req_bor,
    input  logic        req_wd0,
    input  logic        req_wd1,
    input  logic        bor_irq_mode,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sys_rst_pulse,
    output logic        sim_por_pulse
);
    localparam int BOR_IDX = 1;

    logic [N_SRC-1:0]   rise, ev, sim_mask;
    logic [POL_W-1:0]   pol_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               any_sim, any_sys;
    rsc_state_t         state_q, state_d;

    rsc_sync #(.N(N_SRC), .STAGES(2)) u_sync (
        .clk(clk), .por_n(por_n),
        .req_async({req_wd1, req_wd0, req_bor, req_ext}),
        .rise(rise)
    );

    always_comb begin
        ev = rise;
        if (bor_irq_mode) ev[BOR_IDX] = 1'b0;
    end

    rsc_policy u_pol (
        .clk(clk), .por_n(por_n),
        .wr_en(bus_sel && bus_wr && bus_addr == 2'd0),
        .wdata(bus_wdata[POL_W-1:0]),
        .pol_q(pol_q), .sim_mask(sim_mask)
    );

    rsc_cause u_cause (
        .clk(clk), .por_n(por_n), .set_src(ev),
        .clr_en(bus_sel && bus_wr && bus_addr == 2'd1),
        .clr_bits(bus_wdata[CAUSE_W-1:0]),
        .cause_q(cause_q)
    );

    assign any_sim = |(ev & sim_mask);
    assign any_sys = |(ev & ~sim_mask);

    always_comb begin
        if (any_sim)      state_d = ST_SIM;
        else if (any_sys) state_d = ST_SYS;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sys_rst_pulse = 1'b0;
        sim_por_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SYS:  sys_rst_pulse = 1'b1;
            ST_SIM:  sim_por_pulse = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = POL_RSVD_RD | DATA_W'(pol_q);
            2'd1:    bus_rdata = DATA_W'(cause_q);
            default: bus_rdata = '0;
        endcase
    end

    // R11
    out_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(sys_rst_pulse && sim_por_pulse));
    // R8
    sim_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        any_sim |=> sim_por_pulse);
    // R7
    bor_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bor_irq_mode && rise == 4'b0010) |=> (!sys_rst_pulse && !sim_por_pulse));
    // R4
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_pulse || sim_por_pulse) |-> (cause_q[CAUSE_W-1:1] != '0));
endmodule

// File: tb/rst_src_ctrl_test.sv
module rst_src_ctrl_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        req_ext = 0, req_bor = 0, req_wd0 = 0, req_wd1 = 0;
    logic        bor_irq_mode = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        sys_rst_pulse, sim_por_pulse;
    int total = 0, bad = 0;
    int n_sys, n_sim;

    always #10 clk = ~clk;

    rst_src_ctrl uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic fire(logic [3:0] m);
        @(negedge clk);
        {req_wd1, req_wd0, req_bor, req_ext} = m;
        n_sys = 0; n_sim = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            n_sys += sys_rst_pulse;
            n_sim += sim_por_pulse;
            if (i == 5) {req_wd1, req_wd0, req_bor, req_ext} = 4'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, d); chk("R1 policy reset", d, 32'h00FF_FFFF);
        rd(1, d); chk("R5 cause after por", d, 32'h1);
        chk("R11 idle outputs", {sys_rst_pulse, sim_por_pulse}, 0);
    endtask

    task automatic t_sys_ext;
        logic [31:0] d;
        wr(1, 32'h1F);
        rd(1, d); chk("R9 clear all", d, 0);
        wr(0, 32'hAA);
        fire(4'b0001);
        chk("R2 ext sys count", n_sys, 1);
        chk("R2 ext no sim", n_sim, 0);
        chk("R11 held req one sys pulse", n_sys + n_sim, 1);
        rd(1, d); chk("R4 ext cause on sys", d, 32'h02);
        rd(0, d); chk("R6 policy kept", d, 32'h00FF_FFAA);
    endtask

    task automatic t_fields;
        logic [31:0] d;
        wr(0, 32'hDEAD_BEE7);
        rd(0, d); chk("R10 reserved ignored", d, 32'h00FF_FFE7);
        wr(1, 32'h1F);
        fire(4'b0100);
        chk("R2 wd0 sys", {n_sys[7:0], n_sim[7:0]}, 32'h0100);
        fire(4'b0010);
        chk("R3 bor field 1 sim", {n_sys[7:0], n_sim[7:0]}, 32'h0001);
        fire(4'b1000);
        chk("R3 wd1 field 3 sim", {n_sys[7:0], n_sim[7:0]}, 32'h0001);
        rd(1, d); chk("R4 cause bits", d, 32'h1C);
        rd(0, d); chk("R6 policy kept after sim", d, 32'h00FF_FFE7);
        wr(0, 32'h0);
        fire(4'b0001);
        chk("R3 ext field 0 sim", {n_sys[7:0], n_sim[7:0]}, 32'h0001);
    endtask

    task automatic t_bor_irq;
        logic [31:0] d;
        wr(0, 32'hAA);
        wr(1, 32'h1F);
        bor_irq_mode = 1;
        fire(4'b0010);
        chk("R7 no pulse", n_sys + n_sim, 0);
        rd(1, d); chk("R7 no cause", d, 0);
        bor_irq_mode = 0;
    endtask

    task automatic t_multi;
        logic [31:0] d;
        wr(0, 32'hAE);
        wr(1, 32'h1F);
        fire(4'b1111);
        chk("R8 one sim", n_sim, 1);
        chk("R8 no sys", n_sys, 0);
        rd(1, d); chk("R8 all causes", d, 32'h1E);
        wr(1, 32'h06);
        rd(1, d); chk("R9 partial clear", d, 32'h18);
    endtask

    task automatic t_repor;
        logic [31:0] d;
        @(negedge clk); por_n = 0;
        @(negedge clk); por_n = 1;
        rd(0, d); chk("R1 policy after repor", d, 32'h00FF_FFFF);
        rd(1, d); chk("R5 cause after repor", d, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1;
        t_reset();
        t_sys_ext();
        t_fields();
        t_bor_irq();
        t_multi();
        t_repor();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule